// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as binary coded decimal values. A divider outside the block supplies a single-cycle enable once per second. On each enable that is allowed to act, the block advances seconds, minutes and hours. It then carries into day of week, day of month, month and year. The carry respects month lengths and leap years, and it can also flip a century flag under software control.

A host reaches the seven time registers one byte at a time through a register index. A write path and a combinational read path are provided. A serial bus front end drives these paths and raises a read-active signal while it streams clock bytes out. While that signal is high, the block withholds updates so that a multi-byte read always sees one consistent snapshot. A second that arrives during the read is held back and applied right after the read ends.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read seconds 00, minutes 00, index 2 = 0x00 (hours 00, century flags 0), day of week 1, date 01, month 01, year 00, and the halt flag clear.
- R2: Writes and reads are by 3-bit index. The field layout is as follows. Index 0 holds the halt flag in bit 7 and seconds in bits 6:0. Index 1 holds minutes in bits 6:0. Index 2 holds the century-enable flag in bit 7, the century flag in bit 6 and hours in bits 5:0. Index 3 holds the day of week in bits 2:0. Index 4 holds the date in bits 5:0. Index 5 holds the month in bits 4:0. Index 6 holds the year in bits 7:0. Bits outside a field read 0. Index 7 reads 0x00, and writes to it have no effect.
- R3: An applied tick increments seconds in BCD. Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours. Hours wrap 23 to 00 and produce a day carry.
- R4: A day carry advances the day of week, which wraps from 7 to 1.
- R5: A day carry increments the date, which restarts at 01 after the last day of the month. Months 4, 6, 9 and 11 have 30 days. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days.
- R6: February ends on day 29 when the BCD year is divisible by 4, with year 00 counted as a leap year. Otherwise it ends on day 28.
- R7: The month wraps from 12 to 01 and then carries into the year. The year wraps from 99 to 00.
- R8: When the year wraps and the century-enable flag is 1, the century flag inverts. When the century-enable flag is 0, the century flag keeps its value.
- R9: While the halt flag is 1, ticks change no register. Once the flag is cleared, ticks count again.
- R10: While read-active is high, no tick changes any register. A tick seen during that window is applied in the first clock cycle in which read-active is low.
- R11: At most one tick is held during a read. Further ticks in the same window are dropped. If a tick arrives in the very cycle the held one is applied, it is applied one cycle later.
- R12: A host write in the same cycle as a tick wins. The written value is stored and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick_i | input | 1 | One-cycle enable, once per second |
| rd_busy_i | input | 1 | High while the host reads clock registers |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Register index for the write |
| wr_data_i | input | 8 | Write data byte |
| rd_idx_i | input | 3 | Register index for the read |
| rd_data_o | output | 8 | Read data byte (combinational) |

## Verification
Three pairs of functions can land in the same cycle.

- A host write against a tick. The bench drives the write strobe and the tick on the same edge. It then confirms that the written seconds value survives both that edge and the next one.
- The end of a deferred read against a new tick. The bench drops read-active in the same cycle a fresh tick arrives. It then expects exactly two increments over the two following edges.
- A full carry chain that touches every field at once. The bench checks it for each century-flag setting.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

  localparam int IDX_W  = 3;
  localparam int BYTE_W = 8;
  localparam int NREGS  = 1 << IDX_W;

  localparam int SEC_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DOW_W  = 3;
  localparam int DATE_W = 6;
  localparam int MON_W  = 5;

  typedef struct packed {
    logic              halt;
    logic [SEC_W-1:0]  sec;
    logic [SEC_W-1:0]  min;
    logic              cen_en;
    logic              cen;
    logic [HOUR_W-1:0] hour;
    logic [DOW_W-1:0]  dow;
    logic [DATE_W-1:0] date;
    logic [MON_W-1:0]  mon;
    logic [BYTE_W-1:0] yr;
  } rtcc_time_t;

  typedef enum logic [IDX_W-1:0] {
    IX_SEC  = 3'd0,
    IX_MIN  = 3'd1,
    IX_HOUR = 3'd2,
    IX_DOW  = 3'd3,
    IX_DATE = 3'd4,
    IX_MON  = 3'd5,
    IX_YEAR = 3'd6,
    IX_CTRL = 3'd7
  } rtcc_idx_e;

  // BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  // leap test: tens*10+ones mod 4 == (2*tens+ones) mod 4
  function automatic logic is_leap(input logic [7:0] yr);
    logic [4:0] s;
    s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
    is_leap = (s[1:0] == 2'b00);
  endfunction

  // last day of the month, BCD
  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      last_day = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtcc_tick_gate.sv
module rtcc_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic busy_i,
  input  logic halt_i,
  input  logic wr_i,
  output logic apply_o,
  output logic held_o
);

  logic held_q, held_d;
  logic want;

  assign want    = tick_i | held_q;
  assign apply_o = want && !busy_i && !halt_i && !wr_i;
  assign held_o  = held_q;

  always_comb begin
    if (halt_i)      held_d = 1'b0;
    else if (busy_i) held_d = held_q | tick_i;
    else             held_d = held_q & tick_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  // R11: a held tick never gets applied while the host is still reading
  a_r11_held_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && busy_i) |-> !apply_o);

endmodule

// File: rtl/rtcc_advance.sv
module rtcc_advance
  import rtcc_pkg::*;
(
  input  rtcc_time_t cur_i,
  output rtcc_time_t nxt_o,
  output logic       sec_wrap_o,
  output logic       min_wrap_o,
  output logic       day_carry_o,
  output logic       month_end_o,
  output logic       year_wrap_o
);

  logic [7:0] sec8, min8, hour8, date8, mon8, end8;

  assign sec8  = {1'b0, cur_i.sec};
  assign min8  = {1'b0, cur_i.min};
  assign hour8 = {2'b0, cur_i.hour};
  assign date8 = {2'b0, cur_i.date};
  assign mon8  = {3'b0, cur_i.mon};
  assign end8  = last_day(mon8, cur_i.yr);

  assign sec_wrap_o  = sec8 >= 8'h59;
  assign min_wrap_o  = sec_wrap_o && (min8 >= 8'h59);
  assign day_carry_o = min_wrap_o && (hour8 >= 8'h23);
  assign month_end_o = day_carry_o && (date8 >= end8);
  assign year_wrap_o = month_end_o && (mon8 >= 8'h12) && (cur_i.yr >= 8'h99);

  always_comb begin
    logic [7:0] t;
    nxt_o = cur_i;
    t = bcd_inc(sec8);
    nxt_o.sec = sec_wrap_o ? '0 : t[SEC_W-1:0];
    if (sec_wrap_o) begin
      t = bcd_inc(min8);
      nxt_o.min = min_wrap_o ? '0 : t[SEC_W-1:0];
    end
    if (min_wrap_o) begin
      t = bcd_inc(hour8);
      nxt_o.hour = day_carry_o ? '0 : t[HOUR_W-1:0];
    end
    if (day_carry_o) begin
      nxt_o.dow = (cur_i.dow >= 3'd7 || cur_i.dow == 3'd0) ? 3'd1 : cur_i.dow + 3'd1;
      t = bcd_inc(date8);
      nxt_o.date = month_end_o ? 6'h01 : t[DATE_W-1:0];
    end
    if (month_end_o) begin
      t = bcd_inc(mon8);
      nxt_o.mon = (mon8 >= 8'h12) ? 5'h01 : t[MON_W-1:0];
      if (mon8 >= 8'h12) begin
        nxt_o.yr = (cur_i.yr >= 8'h99) ? 8'h00 : bcd_inc(cur_i.yr);
      end
    end
    if (year_wrap_o && cur_i.cen_en) nxt_o.cen = ~cur_i.cen;
  end

endmodule

// File: rtl/rtcc_regfile.sv
module rtcc_regfile
  import rtcc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              apply_i,
  input  rtcc_time_t        nxt_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output rtcc_time_t        cur_o
);

  rtcc_time_t q, d;

  localparam rtcc_time_t RESET_VAL = '{halt: 1'b0, sec: '0, min: '0, cen_en: 1'b0,
                                      cen: 1'b0, hour: '0, dow: 3'd1, date: 6'h01,
                                      mon: 5'h01, yr: 8'h00};

  always_comb begin
    d = q;
    if (wr_en_i) begin
      case (rtcc_idx_e'(wr_idx_i))
        IX_SEC:  begin d.halt = wr_data_i[7]; d.sec = wr_data_i[SEC_W-1:0]; end
        IX_MIN:  d.min = wr_data_i[SEC_W-1:0];
        IX_HOUR: begin
          d.cen_en = wr_data_i[7];
          d.cen    = wr_data_i[6];
          d.hour   = wr_data_i[HOUR_W-1:0];
        end
        IX_DOW:  d.dow  = wr_data_i[DOW_W-1:0];
        IX_DATE: d.date = wr_data_i[DATE_W-1:0];
        IX_MON:  d.mon  = wr_data_i[MON_W-1:0];
        IX_YEAR: d.yr   = wr_data_i;
        default: d = q;
      endcase
    end else if (apply_i) begin
      d = nxt_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= d;
  end

  assign cur_o = q;

  logic [BYTE_W-1:0] view [NREGS];
  assign view[IX_SEC]  = {q.halt, q.sec};
  assign view[IX_MIN]  = {1'b0, q.min};
  assign view[IX_HOUR] = {q.cen_en, q.cen, q.hour};
  assign view[IX_DOW]  = {{(BYTE_W-DOW_W){1'b0}}, q.dow};
  assign view[IX_DATE] = {{(BYTE_W-DATE_W){1'b0}}, q.date};
  assign view[IX_MON]  = {{(BYTE_W-MON_W){1'b0}}, q.mon};
  assign view[IX_YEAR] = q.yr;
  assign view[IX_CTRL] = '0;

  assign rd_data_o = view[rd_idx_i];

  // R12: a write to the seconds register lands regardless of a tick
  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == 3'd0) |=> (q.sec == $past(wr_data_i[SEC_W-1:0])));

  // R4: day of week wraps from 7 to 1
  a_r4_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_i && !wr_en_i && q.dow == 3'd7 && q.hour == 6'h23 && q.min == 7'h59 && q.sec == 7'h59)
    |=> (q.dow == 3'd1));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick_i,
  input  logic       rd_busy_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic [2:0] rd_idx_i,
  output logic [7:0] rd_data_o
);

  rtcc_time_t cur, nxt;
  logic apply, held;
  logic sec_wrap, min_wrap, day_carry, month_end, year_wrap;

  rtcc_tick_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (sec_tick_i),
    .busy_i  (rd_busy_i),
    .halt_i  (cur.halt),
    .wr_i    (wr_en_i),
    .apply_o (apply),
    .held_o  (held)
  );

  rtcc_advance u_adv (
    .cur_i       (cur),
    .nxt_o       (nxt),
    .sec_wrap_o  (sec_wrap),
    .min_wrap_o  (min_wrap),
    .day_carry_o (day_carry),
    .month_end_o (month_end),
    .year_wrap_o (year_wrap)
  );

  rtcc_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .apply_i   (apply),
    .nxt_i     (nxt),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .cur_o     (cur)
  );

  // R10: nothing moves while the host reads
  a_r10_frozen_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_busy_i && !wr_en_i) |=> $stable(cur));

  // R10: a held tick is applied on the first cycle after the read
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !rd_busy_i && !cur.halt && !wr_en_i) |=> (cur.sec != $past(cur.sec)));

  // R9: a halted clock does not count
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.halt && !wr_en_i) |=> $stable(cur));

  // R3: seconds wrap to zero
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && !wr_en_i && sec_wrap) |=> (cur.sec == '0));

  // R8: century flag is untouched when not enabled
  a_r8_cen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur.cen_en && !wr_en_i) |=> $stable(cur.cen));

endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick_i = 1'b0;
  logic       rd_busy_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_idx_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [2:0] rd_idx_i = '0;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_calendar_core dut (
    .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick_i), .rd_busy_i(rd_busy_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );

  task automatic peek(input logic [2:0] idx, input logic [7:0] exp, input string tag);
    rd_idx_i = idx;
    #0.5;
    checks++;
    if (rd_data_o !== exp) begin
      errors++;
      $display("FAIL %s idx %0d: actual %h expected %h", tag, idx, rd_data_o, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] val, input bit with_tick = 0);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = val; sec_tick_i = with_tick;
    @(negedge clk);
    wr_en_i = 1'b0; sec_tick_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick_i = 1'b1;
    @(negedge clk);
    sec_tick_i = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, dw); wr(4, dt); wr(5, mo); wr(6, y);
  endtask

  task automatic t_reset();
    peek(0, 8'h00, "R1"); peek(1, 8'h00, "R1"); peek(2, 8'h00, "R1");
    peek(3, 8'h01, "R1"); peek(4, 8'h01, "R1"); peek(5, 8'h01, "R1");
    peek(6, 8'h00, "R1");
  endtask

  task automatic t_layout();
    wr(1, 8'hFF); peek(1, 8'h7F, "R2");
    wr(3, 8'hA5); peek(3, 8'h05, "R2");
    wr(4, 8'hFF); peek(4, 8'h3F, "R2");
    wr(5, 8'hFF); peek(5, 8'h1F, "R2");
    wr(7, 8'h55); peek(7, 8'h00, "R2");
    wr(2, 8'hD7); peek(2, 8'hD7, "R2");
  endtask

  task automatic t_time_carry();
    set_time(8'h08, 8'h10, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
    tick(); peek(0, 8'h09, "R3");
    tick(); peek(0, 8'h10, "R3 BCD digit carry");
    wr(0, 8'h59); tick(); peek(0, 8'h00, "R3"); peek(1, 8'h11, "R3");
    set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h21);
    tick(); peek(2, 8'h10, "R3 hour"); peek(1, 8'h00, "R3");
  endtask

  task automatic t_day_month();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h30, 8'h04, 8'h21);
    tick(); peek(3, 8'h01, "R4"); peek(4, 8'h01, "R5 30-day");
    peek(5, 8'h05, "R5"); peek(2, 8'h00, "R3 hour wrap");
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h01, 8'h21);
    tick(); peek(4, 8'h31, "R5 31-day"); peek(3, 8'h04, "R4");
  endtask

  task automatic t_feb();
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick(); peek(4, 8'h29, "R6 leap");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
    tick(); peek(4, 8'h01, "R6"); peek(5, 8'h03, "R6");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    tick(); peek(4, 8'h01, "R6 common"); peek(5, 8'h03, "R6");
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    tick(); peek(4, 8'h29, "R6 year 00");
  endtask

  task automatic t_year_century();
    set_time(8'h59, 8'h59, 8'hA3, 8'h07, 8'h31, 8'h12, 8'h99);
    tick();
    peek(2, 8'hC0, "R8 enabled"); peek(6, 8'h00, "R7"); peek(5, 8'h01, "R7");
    peek(4, 8'h01, "R7"); peek(3, 8'h01, "R4"); peek(0, 8'h00, "R3");
    set_time(8'h59, 8'h59, 8'h63, 8'h07, 8'h31, 8'h12, 8'h99);
    tick(); peek(2, 8'h40, "R8 disabled"); peek(6, 8'h00, "R7");
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h45);
    tick(); peek(6, 8'h46, "R7 year inc");
  endtask

  task automatic t_halt();
    wr(0, 8'h95); tick(); tick(); peek(0, 8'h95, "R9 halted");
    wr(0, 8'h15); tick(); peek(0, 8'h16, "R9 resumed");
  endtask

  task automatic t_defer();
    wr(0, 8'h10);
    @(negedge clk); rd_busy_i = 1'b1;
    tick(); repeat (3) @(negedge clk);
    peek(0, 8'h10, "R10 frozen");
    rd_busy_i = 1'b0;
    @(negedge clk); peek(0, 8'h11, "R10 applied");
    @(negedge clk); rd_busy_i = 1'b1;
    tick(); tick(); tick();
    rd_busy_i = 1'b0;
    repeat (3) @(negedge clk); peek(0, 8'h12, "R11 one held");
    @(negedge clk); rd_busy_i = 1'b1;
    tick();
    rd_busy_i = 1'b0; sec_tick_i = 1'b1;
    @(negedge clk); sec_tick_i = 1'b0;
    @(negedge clk); peek(0, 8'h14, "R11 coincident");
  endtask

  task automatic t_write_wins();
    wr(0, 8'h20);
    wr(0, 8'h30, 1'b1); peek(0, 8'h30, "R12");
    @(negedge clk); peek(0, 8'h30, "R12 no late tick");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_time_carry();
    t_day_month();
    t_feb();
    t_year_century();
    t_halt();
    t_defer();
    t_write_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule